// File: doc/BRIEF.md
# Object Descriptor Address Translator

This block turns an object-relative load or store into a physical address. The requester names the object with a 32-bit access descriptor. The low 26 bits of the descriptor are an object index, and the two bits above the index carry read and write rights. The requester also supplies a base offset, a displacement and an index value, plus a flag that adds the index value. The block sums these parts into an effective offset. It then reads the indexed entry of an internal object descriptor table, checks the request's rights and the object's length, and produces a physical address or a fault code.

Each descriptor holds a kind, a length in bytes and a base address. A direct object adds the offset to its base. A single-level paged object uses the base as the start of a page table. A two-level paged object uses the base as the start of a top-level table. Pages are 4 KiB and table entries are 4 bytes wide. The block reads the page tables through a simple memory read port, with one read in flight at a time. Each accepted request gets exactly one response, which is a one-cycle pulse.

Top module: `odt_xlate`

## Requirements
- R1: The effective offset is base + displacement, plus the index value when `req_idx_en_i` is 1, taken modulo 2^32. A direct object (kind 1) answers with paddr = descriptor base + offset and fault code 0. This response comes two cycles after the request is accepted and issues no memory read.
- R2: A descriptor is valid only if its kind is not 0. An object index at or above the table depth, or one that selects a kind-0 entry, gives fault code 1 and issues no memory read. A descriptor write applies to requests accepted after the clock edge that performs it.
- R3: Bit 26 of the access descriptor grants read and bit 27 grants write. A load without read right, or a store without write right, gives fault code 2.
- R4: An offset greater than or equal to the descriptor length gives fault code 3. No page-table read is issued for it.
- R5: For a single-level object (kind 2), the block reads one entry at base + (offset[31:12] * 4). The result is paddr = {entry[31:12], offset[11:0]}.
- R6: For a two-level object (kind 3), the block first reads the top entry at base + (offset[31:22] * 4). It then reads the leaf entry at {top[31:12], 12'h000} + (offset[21:12] * 4). The result is paddr = {leaf[31:12], offset[11:0]}.
- R7: A table entry with bit 0 clear gives fault code 4. No further read follows it.
- R8: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` arrives. Only one read is in flight at a time.
- R9: When several checks fail together, the reported code follows this order: object (1) over permission (2) over bounds (3).
- R10: `req_ready_o` is low while a request is in progress, and requests offered during that time are ignored. `rsp_valid_o` is high for exactly one cycle per accepted request.
- R11: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_o` are 0.
- R12: A faulting response drives `rsp_fault_o` = 1 and `rsp_paddr_o` = 0. A good response drives `rsp_fault_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_ad_i | input | 32 | Access descriptor: rights in bits 27:26, object index in bits 25:0 |
| req_base_i | input | 32 | Base offset |
| req_disp_i | input | 32 | Extra displacement |
| req_idx_i | input | 32 | Index value |
| req_idx_en_i | input | 1 | Add index value to the offset |
| req_store_i | input | 1 | 1 = store, 0 = load |
| desc_we_i | input | 1 | Write descriptor table entry |
| desc_sel_i | input | SEL_W (4) | Table entry to write |
| desc_kind_i | input | 2 | 0 invalid, 1 direct, 2 single-level paged, 3 two-level paged |
| desc_len_i | input | 32 | Object length in bytes |
| desc_base_i | input | 32 | Data base or table base |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table entry byte address |
| mem_rdata_i | input | 32 | Table entry read data |
| mem_rvalid_i | input | 1 | Read data valid |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_code_o | output | 3 | 0 ok, 1 object, 2 permission, 3 bounds, 4 page |
| rsp_paddr_o | output | 32 | Physical address |

## Verification
Two things can go wrong in the same check cycle. A request can lack the needed right and also run past the object's length. An invalid object can also carry no rights at all. The bench drives vectors built to fail more than one check and expects only the higher-ranked code. A second kind of overlap is a new request offered while a table walk is still waiting on memory. The bench offers such a request and judges by what the ports show: `req_ready_o` stays low, the one response carries the first request's address, and no second response follows.

// File: rtl/odt_pkg.sv
package odt_pkg;
  localparam int ADDR_W    = 32;
  localparam int OBJ_IDX_W = 26;
  localparam int PERM_RD   = 26;
  localparam int PERM_WR   = 27;
  localparam int PAGE_W    = 12;
  localparam int LEAF_W    = 10;
  localparam int PTE_SH    = 2;
  localparam int TOP_W     = ADDR_W - PAGE_W - LEAF_W;

  typedef enum logic [1:0] {
    OK_NONE   = 2'd0,
    OK_DIRECT = 2'd1,
    OK_PAGED1 = 2'd2,
    OK_PAGED2 = 2'd3
  } obj_kind_e;

  typedef enum logic [2:0] {
    FC_OK     = 3'd0,
    FC_OBJECT = 3'd1,
    FC_PERM   = 3'd2,
    FC_BOUNDS = 3'd3,
    FC_PAGE   = 3'd4
  } fault_e;

  typedef struct packed {
    obj_kind_e          kind;
    logic [ADDR_W-1:0]  len;
    logic [ADDR_W-1:0]  base;
  } desc_t;
endpackage

// File: rtl/odt_offset.sv
module odt_offset
  import odt_pkg::*;
#(
  parameter bit HAS_INDEX = 1'b1
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              idx_en_i,
  output logic [ADDR_W-1:0] off_o
);
  logic [ADDR_W-1:0] idx_term;

  generate
    if (HAS_INDEX) begin : g_idx
      assign idx_term = idx_en_i ? idx_i : '0;
    end else begin : g_noidx
      logic unused_idx;
      assign unused_idx = ^{idx_i, idx_en_i};
      assign idx_term   = '0;
    end
  endgenerate

  assign off_o = base_i + disp_i + idx_term;
endmodule

// File: rtl/odt_desc_tbl.sv
module odt_desc_tbl
  import odt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     wsel_i,
  input  desc_t                wdata_i,
  input  logic [OBJ_IDX_W-1:0] ridx_i,
  output desc_t                rdata_o
);
  desc_t ent [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 ent[g] <= '0;
        else if (we_i && wsel_i == SEL_W'(g))        ent[g] <= wdata_i;
      end
    end
  endgenerate

  logic in_range;
  assign in_range = (ridx_i < OBJ_IDX_W'(DEPTH));

  always_comb begin
    rdata_o = '0;
    if (in_range) rdata_o = ent[ridx_i[SEL_W-1:0]];
  end
endmodule

// File: rtl/odt_walk.sv
module odt_walk
  import odt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  desc_t             desc_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              store_i,
  input  logic              rd_ok_i,
  input  logic              wr_ok_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              rsp_valid_o,
  output fault_e            rsp_code_o,
  output logic [ADDR_W-1:0] rsp_paddr_o
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_TOP, S_LEAF, S_RESP} state_e;

  state_e            state_q;
  desc_t             desc_q;
  logic [ADDR_W-1:0] off_q, pt_addr_q, paddr_q;
  logic              st_q, rd_q, wr_q;
  fault_e            code_q, chk_code;

  logic [ADDR_W-PAGE_W-1:0] pn;
  logic [TOP_W-1:0]         top_ix;
  logic [LEAF_W-1:0]        mid_ix;
  logic [ADDR_W-1:0]        frame;

  assign pn     = off_q[ADDR_W-1:PAGE_W];
  assign top_ix = off_q[ADDR_W-1:PAGE_W+LEAF_W];
  assign mid_ix = off_q[PAGE_W+LEAF_W-1:PAGE_W];
  assign frame  = {mem_rdata_i[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};

  // priority: object, permission, bounds
  always_comb begin
    if (desc_q.kind == OK_NONE)        chk_code = FC_OBJECT;
    else if (st_q ? !wr_q : !rd_q)     chk_code = FC_PERM;
    else if (off_q >= desc_q.len)      chk_code = FC_BOUNDS;
    else                               chk_code = FC_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      desc_q    <= '0;
      off_q     <= '0;
      st_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      pt_addr_q <= '0;
      paddr_q   <= '0;
      code_q    <= FC_OK;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          desc_q  <= desc_i;
          off_q   <= off_i;
          st_q    <= store_i;
          rd_q    <= rd_ok_i;
          wr_q    <= wr_ok_i;
          code_q  <= FC_OK;
          paddr_q <= '0;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (chk_code != FC_OK) begin
            code_q  <= chk_code;
            state_q <= S_RESP;
          end else begin
            case (desc_q.kind)
              OK_PAGED1: begin
                pt_addr_q <= desc_q.base + (ADDR_W'(pn) << PTE_SH);
                state_q   <= S_LEAF;
              end
              OK_PAGED2: begin
                pt_addr_q <= desc_q.base + (ADDR_W'(top_ix) << PTE_SH);
                state_q   <= S_TOP;
              end
              default: begin
                paddr_q <= desc_q.base + off_q;
                state_q <= S_RESP;
              end
            endcase
          end
        end
        S_TOP: if (mem_rvalid_i) begin
          if (!mem_rdata_i[0]) begin
            code_q  <= FC_PAGE;
            state_q <= S_RESP;
          end else begin
            pt_addr_q <= frame + (ADDR_W'(mid_ix) << PTE_SH);
            state_q   <= S_LEAF;
          end
        end
        S_LEAF: if (mem_rvalid_i) begin
          if (!mem_rdata_i[0]) code_q <= FC_PAGE;
          else paddr_q <= {mem_rdata_i[ADDR_W-1:PAGE_W], off_q[PAGE_W-1:0]};
          state_q <= S_RESP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_TOP) || (state_q == S_LEAF);
  assign mem_addr_o  = pt_addr_q;
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_code_o  = code_q;
  assign rsp_paddr_o = paddr_q;

  a_r4_no_read_past_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (off_q < desc_q.len));
  a_r2_read_only_paged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (desc_q.kind == OK_PAGED1 || desc_q.kind == OK_PAGED2));
  a_r8_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && ready_o));
  a_r10_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !ready_o);
  a_r12_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o != FC_OK) |-> (rsp_paddr_o == '0));
  a_r3_rights_on_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == FC_OK) |-> (st_q ? wr_q : rd_q));
  a_r7_page_needs_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == FC_PAGE) |-> (desc_q.kind != OK_DIRECT));
endmodule

// File: rtl/odt_xlate.sv
module odt_xlate
  import odt_pkg::*;
#(
  parameter int DESC_DEPTH = 16,
  localparam int SEL_W = $clog2(DESC_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_ad_i,
  input  logic [31:0]       req_base_i,
  input  logic [31:0]       req_disp_i,
  input  logic [31:0]       req_idx_i,
  input  logic              req_idx_en_i,
  input  logic              req_store_i,
  input  logic              desc_we_i,
  input  logic [SEL_W-1:0]  desc_sel_i,
  input  logic [1:0]        desc_kind_i,
  input  logic [31:0]       desc_len_i,
  input  logic [31:0]       desc_base_i,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [2:0]        rsp_code_o,
  output logic [31:0]       rsp_paddr_o
);
  desc_t             wdesc, rdesc;
  logic [ADDR_W-1:0] off;
  logic              start;
  fault_e            code;
  logic [ADDR_W-1:0] unused_ad_hi;

  assign wdesc = '{kind: obj_kind_e'(desc_kind_i), len: desc_len_i, base: desc_base_i};
  assign start = req_valid_i && req_ready_o;
  assign unused_ad_hi = ADDR_W'(req_ad_i[31:28]);

  odt_offset #(.HAS_INDEX(1'b1)) u_off (
    .base_i  (req_base_i),
    .disp_i  (req_disp_i),
    .idx_i   (req_idx_i),
    .idx_en_i(req_idx_en_i),
    .off_o   (off)
  );

  odt_desc_tbl #(.DEPTH(DESC_DEPTH)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (desc_we_i),
    .wsel_i (desc_sel_i),
    .wdata_i(wdesc),
    .ridx_i (req_ad_i[OBJ_IDX_W-1:0]),
    .rdata_o(rdesc)
  );

  odt_walk u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .desc_i      (rdesc),
    .off_i       (off),
    .store_i     (req_store_i),
    .rd_ok_i     (req_ad_i[PERM_RD]),
    .wr_ok_i     (req_ad_i[PERM_WR]),
    .ready_o     (req_ready_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_rvalid_i(mem_rvalid_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_code_o  (code),
    .rsp_paddr_o (rsp_paddr_o)
  );

  assign rsp_code_o  = code;
  assign rsp_fault_o = (code != FC_OK);

  a_r12_fault_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o == (rsp_code_o != 3'd0)));
endmodule

// File: tb/odt_xlate_tb.sv
module odt_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_idx_en = 1'b0, req_store = 1'b0;
  logic [31:0] req_ad = '0, req_base = '0, req_disp = '0, req_idx = '0;
  logic        desc_we = 1'b0;
  logic [3:0]  desc_sel = '0;
  logic [1:0]  desc_kind = '0;
  logic [31:0] desc_len = '0, desc_base = '0;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_paddr;
  int          rd_count;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  odt_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_ad_i(req_ad),
    .req_base_i(req_base), .req_disp_i(req_disp), .req_idx_i(req_idx),
    .req_idx_en_i(req_idx_en), .req_store_i(req_store),
    .desc_we_i(desc_we), .desc_sel_i(desc_sel), .desc_kind_i(desc_kind),
    .desc_len_i(desc_len), .desc_base_i(desc_base),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_rvalid_i(mem_rvalid),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_code_o(rsp_code),
    .rsp_paddr_o(rsp_paddr)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h0000_0000: return 32'h0000_1001;  // top[0] -> leaf table 0x1000
      32'h0000_0004: return 32'h0000_0000;  // top[1] invalid
      32'h0000_0200: return 32'h0005_0001;
      32'h0000_0204: return 32'h0007_3001;
      32'h0000_0208: return 32'h0000_0000;
      32'h0000_1000: return 32'h0009_9001;
      32'h0000_1004: return 32'h000A_A001;
      32'h0000_1008: return 32'h0000_0000;
      default:       return 32'h0000_0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      rd_count   <= 0;
    end else if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem_word(mem_addr);
      rd_count   <= rd_count + 1;
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  typedef struct packed {
    logic [31:0] ad, boff, disp, idx;
    logic        ien, st;
    logic [2:0]  code;
    logic [31:0] pa;
    logic [1:0]  reads;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{32'h0C00_0000, 32'h10, 32'h4, 32'h100, 1'b1, 1'b0, 3'd0, 32'h8000_0114, 2'd0, 4'd1},  // R1 index on
    '{32'h0C00_0000, 32'h10, 32'h4, 32'h100, 1'b0, 1'b0, 3'd0, 32'h8000_0014, 2'd0, 4'd1},  // R1 index off
    '{32'h0C00_0004, 32'h5,  32'h4, 32'h6,   1'b1, 1'b0, 3'd0, 32'h0000_400F, 2'd0, 4'd1},  // R1
    '{32'h0C00_0001, 32'h1000, 32'h234, 32'h0, 1'b0, 1'b0, 3'd0, 32'h0007_3234, 2'd1, 4'd5}, // R5
    '{32'h0C00_0001, 32'h10, 32'h0, 32'h0,   1'b0, 1'b1, 3'd0, 32'h0005_0010, 2'd1, 4'd5},  // R5 store
    '{32'h0C00_0001, 32'h2010, 32'h0, 32'h0, 1'b0, 1'b0, 3'd4, 32'h0, 2'd1, 4'd7},          // R7 leaf
    '{32'h0C00_0002, 32'h1ABC, 32'h0, 32'h0, 1'b0, 1'b0, 3'd0, 32'h000A_AABC, 2'd2, 4'd6},  // R6
    '{32'h0C00_0002, 32'h0ABC, 32'h0, 32'h0, 1'b0, 1'b1, 3'd0, 32'h0009_9ABC, 2'd2, 4'd6},  // R6
    '{32'h0C00_0002, 32'h2000, 32'h0, 32'h0, 1'b0, 1'b0, 3'd4, 32'h0, 2'd2, 4'd7},          // R7 leaf
    '{32'h0C00_0002, 32'h0040_0000, 32'h0, 32'h0, 1'b0, 1'b0, 3'd4, 32'h0, 2'd1, 4'd7},     // R7 top
    '{32'h0C00_0000, 32'h1000, 32'h0, 32'h0, 1'b0, 1'b0, 3'd3, 32'h0, 2'd0, 4'd4},          // R4 at len
    '{32'h0C00_0000, 32'h0FFF, 32'h0, 32'h0, 1'b0, 1'b0, 3'd0, 32'h8000_0FFF, 2'd0, 4'd4},  // R4 last byte
    '{32'h0C00_0001, 32'h3000, 32'h0, 32'h0, 1'b0, 1'b0, 3'd3, 32'h0, 2'd0, 4'd4},          // R4 paged, no read
    '{32'h0400_0000, 32'h0, 32'h0, 32'h0,    1'b0, 1'b1, 3'd2, 32'h0, 2'd0, 4'd3},          // R3 store, read only
    '{32'h0800_0000, 32'h0, 32'h0, 32'h0,    1'b0, 1'b0, 3'd2, 32'h0, 2'd0, 4'd3},          // R3 load, write only
    '{32'h0800_0000, 32'h0, 32'h0, 32'h0,    1'b0, 1'b1, 3'd0, 32'h8000_0000, 2'd0, 4'd3},  // R3 store ok
    '{32'h0C00_0003, 32'h0, 32'h0, 32'h0,    1'b0, 1'b0, 3'd1, 32'h0, 2'd0, 4'd2},          // R2 kind 0
    '{32'h0C00_0014, 32'h0, 32'h0, 32'h0,    1'b0, 1'b0, 3'd1, 32'h0, 2'd0, 4'd2},          // R2 beyond depth
    '{32'h0000_0003, 32'h9000, 32'h0, 32'h0, 1'b0, 1'b1, 3'd1, 32'h0, 2'd0, 4'd9},          // R9 object first
    '{32'h0000_0000, 32'h2000, 32'h0, 32'h0, 1'b0, 1'b0, 3'd2, 32'h0, 2'd0, 4'd9},          // R9 perm over bounds
    '{32'h0C00_0001, 32'hFFFF_FFF0, 32'h20, 32'h0, 1'b0, 1'b0, 3'd0, 32'h0005_0010, 2'd1, 4'd1} // R1 wrap
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr_desc(input logic [3:0] s, input logic [1:0] k,
                         input logic [31:0] l, input logic [31:0] b);
    @(negedge clk);
    desc_we = 1'b1; desc_sel = s; desc_kind = k; desc_len = l; desc_base = b;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    req_ad = v.ad; req_base = v.boff; req_disp = v.disp; req_idx = v.idx;
    req_idx_en = v.ien; req_store = v.st; req_valid = 1'b1;
  endtask

  task automatic wait_rsp(output int lat);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int lat, r0;
    r0 = rd_count;
    send(v);
    wait_rsp(lat);
    check(rsp_valid == 1'b1, v.req, "response seen", 32'(rsp_valid), 32'd1);
    check(rsp_code == v.code, v.req, "code", 32'(rsp_code), 32'(v.code));
    check(rsp_paddr == v.pa, v.req, "paddr", rsp_paddr, v.pa);
    check(rsp_fault == (v.code != 3'd0), 12, "fault flag R12", 32'(rsp_fault), 32'(v.code != 3'd0));
    check((rd_count - r0) == int'(v.reads), v.req, "table reads", 32'(rd_count - r0), 32'(v.reads));
    if (v.reads == 2'd0)
      check(lat == 2, v.req, "latency R1", 32'(lat), 32'd2);
    @(negedge clk);
    check(rsp_valid == 1'b0, 10, "pulse ends R10", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, nrsp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(req_ready == 1'b1, 11, "ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, 11, "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check(mem_req == 1'b0, 11, "mem_req after reset", 32'(mem_req), 32'd0);

    wr_desc(4'd0, 2'd1, 32'h0000_1000, 32'h8000_0000);
    wr_desc(4'd1, 2'd2, 32'h0000_3000, 32'h0000_0200);
    wr_desc(4'd2, 2'd3, 32'h0080_0000, 32'h0000_0000);
    wr_desc(4'd3, 2'd0, 32'hFFFF_FFFF, 32'h0);
    wr_desc(4'd4, 2'd1, 32'h0000_0010, 32'h0000_4000);

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R2 rewrite: entry 3 becomes direct and is then usable
    wr_desc(4'd3, 2'd1, 32'h100, 32'h0002_0000);
    run_vec('{32'h0C00_0003, 32'h20, 32'h0, 32'h0, 1'b0, 1'b0, 3'd0, 32'h0002_0020, 2'd0, 4'd2});

    // R10 request offered while a two-level walk is busy is ignored
    send('{32'h0C00_0002, 32'h1ABC, 32'h0, 32'h0, 1'b0, 1'b0, 3'd0, 32'h0, 2'd0, 4'd10});
    @(negedge clk);
    req_ad = 32'h0C00_0000; req_base = 32'h44; req_valid = 1'b1;
    check(req_ready == 1'b0, 10, "ready low while busy", 32'(req_ready), 32'd0);
    wait_rsp(lat);
    check(rsp_valid == 1'b1, 10, "busy response", 32'(rsp_valid), 32'd1);
    check(rsp_paddr == 32'h000A_AABC, 10, "busy paddr", rsp_paddr, 32'h000A_AABC);
    nrsp = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (rsp_valid) nrsp++;
    end
    check(nrsp == 0, 10, "no extra response", 32'(nrsp), 32'd0);
    check(req_ready == 1'b1, 10, "ready after busy", 32'(req_ready), 32'd1);
    check(mem_req == 1'b0, 8, "no read left in flight R8", 32'(mem_req), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule